// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the serial side of a PHY management port. A host places a 5-bit PHY address, a 5-bit register number, a read/write select and a 16-bit write word on its inputs, then pulses `start`. The block then produces one complete management frame on a clock pin, a data-out pin and an output-enable pin. On a read it also collects 16 bits from the data-in pin. When the frame is over it pulses `done`. On a read, the word on `rd_data` is updated in that same cycle.

Every bit cell has two halves of `HALF_CYC` system clocks each. In the first half the management clock is low and the output bit is presented. In the second half the management clock is high, and input is sampled on the system edge that raises it. Every frame opens with a preamble of `PRE_LEN` ones. A start code, an opcode and the two address fields follow. After that the frame differs by direction. A write has two released turnaround cells, 16 data cells and one released closing cell, for 65 cells in all. A read releases the line right after the register field and has one turnaround cell, 16 sampled cells and one released closing cell, for 64 cells in all.

The controller is a state machine. Its states are `ST_IDLE`, `ST_PRE`, `ST_SOF`, `ST_OP`, `ST_PHY`, `ST_REG`, `ST_TA`, `ST_WDAT`, `ST_RDAT` and `ST_END`. Its transitions are as follows. IDLE goes to PRE when `start` arrives. PRE goes to SOF after the last preamble cell. SOF goes to OP, OP goes to PHY and PHY goes to REG, each after its last cell. REG goes to TA. TA goes to RDAT on a read and to WDAT on a write. WDAT and RDAT each go to END. END goes back to IDLE and raises `done`.

Top module: `mdio_frame_master`

## Requirements
- R1: Every frame begins with 32 cells in which the output is enabled and driven to 1.
- R2: After the preamble come two start cells, 0 then 1. Then come two opcode cells: 1,0 for a read (`rd_nwr`=1) and 0,1 for a write (`rd_nwr`=0). All four cells are driven.
- R3: The next 10 cells are driven. They carry the PHY address and then the register number, each 5 bits wide and most significant bit first.
- R4: A write continues with 2 cells with the output released, then 16 driven cells carrying `wr_data` most significant bit first, then 1 released cell, for 65 cells in total.
- R5: A read releases the output for the rest of the frame. The data-in value at the clock rise of cells 47 to 62 (counted from 0) forms `rd_data`, most significant bit first. Cell 46 is the turnaround cell and cell 63 closes the frame, for 64 cells in total.
- R6: Each clock half lasts exactly `HALF_CYC` system clocks. `done` rises `cells*2*HALF_CYC` system clocks after the edge that accepts `start`. Data-in is sampled on the edge that raises the clock.
- R7: After reset and whenever the block is idle, the clock, data-out and output-enable pins are all 0, and `busy`, `done` and `rd_data` start at 0.
- R8: `busy` is high from the cycle after acceptance until the cycle in which `done` pulses, and `done` lasts one cycle. A `start` or a field change while busy does not alter the frame in flight.
- R9: A write frame leaves `rd_data` at its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a frame (taken only when idle) |
| rd_nwr | input | 1 | 1 = read frame, 0 = write frame |
| phy_addr | input | AW | PHY address |
| reg_addr | input | AW | Register number |
| wr_data | input | DW | Word to write |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | DW | Word captured by the last read |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Management data out |
| mdo_en | output | 1 | Output enable for data out |
| mdi | input | 1 | Management data in |

## Verification
A field counter that starts from the wrong value, or a state that moves on one cell early, shifts every cell after it. The pin log of that frame then departs from the expected cell pattern at the first cell affected, and the cell count and the time to `done` no longer match. A capture point one cell off shows up in `rd_data` at the end of the very next read, because cells outside the sampling window are driven with a pattern that differs from the read word. A wrong half-period count alters the length of every clock half, so it appears within the first cell.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_SOF,
        ST_OP,
        ST_PHY,
        ST_REG,
        ST_TA,
        ST_WDAT,
        ST_RDAT,
        ST_END
    } mdio_state_e;
endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int TW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [TW-1:0] cnt;

    assign tick = run && (cnt == TW'(HALF_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r6_tick_bound: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= TW'(HALF_CYC - 1)));
endmodule

// File: rtl/mdio_tx_bit.sv
module mdio_tx_bit import mdio_mgmt_pkg::*; #(
    parameter int AW = 5,
    parameter int DW = 16,
    parameter int BW = 6
) (
    input  mdio_state_e   st,
    input  logic [BW-1:0] bcnt,
    input  logic          rd,
    input  logic [AW-1:0] phy,
    input  logic [AW-1:0] rg,
    input  logic [DW-1:0] wd,
    output logic          drv,
    output logic          bit_o
);
    logic [AW-1:0] phy_sh;
    logic [AW-1:0] rg_sh;
    logic [DW-1:0] wd_sh;

    assign phy_sh = phy >> bcnt;
    assign rg_sh  = rg >> bcnt;
    assign wd_sh  = wd >> bcnt;

    always_comb begin
        drv   = 1'b0;
        bit_o = 1'b0;
        unique case (st)
            ST_PRE: begin
                drv   = 1'b1;
                bit_o = 1'b1;
            end
            ST_SOF: begin
                drv   = 1'b1;
                bit_o = (bcnt == '0);
            end
            ST_OP: begin
                drv   = 1'b1;
                bit_o = rd ? (bcnt == BW'(1)) : (bcnt == '0);
            end
            ST_PHY: begin
                drv   = 1'b1;
                bit_o = phy_sh[0];
            end
            ST_REG: begin
                drv   = 1'b1;
                bit_o = rg_sh[0];
            end
            ST_WDAT: begin
                drv   = 1'b1;
                bit_o = wd_sh[0];
            end
            default: begin
                drv   = 1'b0;
                bit_o = 1'b0;
            end
        endcase
    end

    a_r7_quiet_when_released: assert final (drv || !bit_o);
endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          smp,
    input  logic          mdi,
    output logic [DW-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            word <= '0;
        end else if (smp) begin
            word <= {word[DW-2:0], mdi};
        end
    end

    a_r5_no_sample_on_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (word == '0));
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master import mdio_mgmt_pkg::*; #(
    parameter int HALF_CYC = 4,
    parameter int PRE_LEN  = 32,
    parameter int AW       = 5,
    parameter int DW       = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          rd_nwr,
    input  logic [AW-1:0] phy_addr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] wr_data,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic          mdc,
    output logic          mdo,
    output logic          mdo_en,
    input  logic          mdi
);
    localparam int MAXF = (PRE_LEN > DW) ? PRE_LEN : DW;
    localparam int BW   = $clog2(MAXF + 1);
    localparam int RW   = $clog2(HALF_CYC + 2);

    mdio_state_e   state;
    mdio_state_e   nxt_state;
    logic          phase_hi;
    logic          nxt_phase;
    logic [BW-1:0] bcnt;
    logic [BW-1:0] nxt_bcnt;
    logic          rd_q;
    logic [AW-1:0] phy_q;
    logic [AW-1:0] reg_q;
    logic [DW-1:0] wd_q;
    logic [DW-1:0] rx_word;
    logic          run;
    logic          tick;
    logic          accept;
    logic          finish;
    logic          last_bit;
    logic          smp;
    logic          drv;
    logic          dbit;

    assign run      = (state != ST_IDLE);
    assign busy     = run;
    assign last_bit = tick && phase_hi && (bcnt == '0);
    assign smp      = (state == ST_RDAT) && !phase_hi && tick;

    mdio_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    mdio_rx_shift #(.DW(DW)) u_rx (
        .clk  (clk),
        .rst  (rst),
        .clr  (accept),
        .smp  (smp),
        .mdi  (mdi),
        .word (rx_word)
    );

    mdio_tx_bit #(.AW(AW), .DW(DW), .BW(BW)) u_tx (
        .st    (nxt_state),
        .bcnt  (nxt_bcnt),
        .rd    (rd_q),
        .phy   (phy_q),
        .rg    (reg_q),
        .wd    (wd_q),
        .drv   (drv),
        .bit_o (dbit)
    );

    // next-state logic
    always_comb begin
        nxt_state = state;
        nxt_phase = phase_hi;
        nxt_bcnt  = bcnt;
        accept    = 1'b0;
        finish    = 1'b0;
        if (run && tick) begin
            nxt_phase = !phase_hi;
            if (phase_hi && (bcnt != '0)) begin
                nxt_bcnt = bcnt - 1'b1;
            end
        end
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    accept    = 1'b1;
                    nxt_state = ST_PRE;
                    nxt_phase = 1'b0;
                    nxt_bcnt  = BW'(PRE_LEN - 1);
                end
            end
            ST_PRE: begin
                if (last_bit) begin
                    nxt_state = ST_SOF;
                    nxt_bcnt  = BW'(1);
                end
            end
            ST_SOF: begin
                if (last_bit) begin
                    nxt_state = ST_OP;
                    nxt_bcnt  = BW'(1);
                end
            end
            ST_OP: begin
                if (last_bit) begin
                    nxt_state = ST_PHY;
                    nxt_bcnt  = BW'(AW - 1);
                end
            end
            ST_PHY: begin
                if (last_bit) begin
                    nxt_state = ST_REG;
                    nxt_bcnt  = BW'(AW - 1);
                end
            end
            ST_REG: begin
                if (last_bit) begin
                    nxt_state = ST_TA;
                    nxt_bcnt  = rd_q ? BW'(0) : BW'(1);
                end
            end
            ST_TA: begin
                if (last_bit) begin
                    nxt_state = rd_q ? ST_RDAT : ST_WDAT;
                    nxt_bcnt  = BW'(DW - 1);
                end
            end
            ST_WDAT, ST_RDAT: begin
                if (last_bit) begin
                    nxt_state = ST_END;
                    nxt_bcnt  = '0;
                end
            end
            ST_END: begin
                if (last_bit) begin
                    nxt_state = ST_IDLE;
                    finish    = 1'b1;
                end
            end
            default: begin
                nxt_state = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            phase_hi <= 1'b0;
            bcnt     <= '0;
        end else begin
            state    <= nxt_state;
            phase_hi <= nxt_phase;
            bcnt     <= nxt_bcnt;
        end
    end

    // request capture
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= 1'b0;
            phy_q <= '0;
            reg_q <= '0;
            wd_q  <= '0;
        end else if (accept) begin
            rd_q  <= rd_nwr;
            phy_q <= phy_addr;
            reg_q <= reg_addr;
            wd_q  <= wr_data;
        end
    end

    // registered outputs, taken from next-state values
    always_ff @(posedge clk) begin
        if (rst) begin
            mdc     <= 1'b0;
            mdo     <= 1'b0;
            mdo_en  <= 1'b0;
            done    <= 1'b0;
            rd_data <= '0;
        end else begin
            mdc    <= (nxt_state != ST_IDLE) && nxt_phase;
            mdo    <= drv && dbit;
            mdo_en <= drv;
            done   <= finish;
            if (finish && rd_q) begin
                rd_data <= rx_word;
            end
        end
    end

    // checker state: length of the current clock level
    logic          mdc_d;
    logic [RW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            mdc_d   <= 1'b0;
            run_len <= '0;
        end else begin
            mdc_d <= mdc;
            if (!busy) begin
                run_len <= '0;
            end else if (mdc != mdc_d) begin
                run_len <= RW'(1);
            end else begin
                run_len <= run_len + 1'b1;
            end
        end
    end

    a_r6_half_len: assert property (@(posedge clk) disable iff (rst)
        (mdc != mdc_d) |-> (run_len == RW'(HALF_CYC)));

    a_r6_sample_at_rise: assert property (@(posedge clk) disable iff (rst)
        smp |=> (mdc && !mdc_d));

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdo && !mdo_en));

    a_r1_pre_driven: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PRE) |-> (mdo_en && mdo));

    a_r5_read_released: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RDAT || state == ST_END) |-> (!mdo_en && !mdo));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r9_write_keeps_data: assert property (@(posedge clk) disable iff (rst)
        (done && !rd_q) |-> $stable(rd_data));
endmodule

// File: tb/mdio_frame_master_test.sv
module mdio_frame_master_test;
    localparam int H = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        rd_nwr = 1'b0;
    logic [4:0]  pa = '0;
    logic [4:0]  ra = '0;
    logic [15:0] wd = '0;
    logic        busy, done, mdc, mdo, mdo_en;
    logic [15:0] rd_data;
    logic        mdi;

    int n_chk = 0;
    int n_bad = 0;
    bit fin = 1'b0;

    int          cell_cnt = 0;
    logic [15:0] phy_val = '0;
    logic [15:0] last_rd = '0;
    logic        log_oe  [0:127];
    logic        log_mdo [0:127];

    always #2.5 clk = ~clk;

    mdio_frame_master #(.HALF_CYC(H)) uut (
        .clk(clk), .rst(rst), .start(start), .rd_nwr(rd_nwr),
        .phy_addr(pa), .reg_addr(ra), .wr_data(wd),
        .busy(busy), .done(done), .rd_data(rd_data),
        .mdc(mdc), .mdo(mdo), .mdo_en(mdo_en), .mdi(mdi)
    );

    // PHY model: log each cell at the clock rise, advance at the fall
    always @(posedge mdc) begin
        if (cell_cnt < 128) begin
            log_oe[cell_cnt]  = mdo_en;
            log_mdo[cell_cnt] = mdo;
        end
    end
    always @(negedge mdc) cell_cnt = cell_cnt + 1;

    always @* begin
        if (cell_cnt >= 47 && cell_cnt <= 62) mdi = phy_val[62 - cell_cnt];
        else mdi = ~phy_val[cell_cnt % 16];
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_cell(bit rd, logic [4:0] a, logic [4:0] r,
                                            logic [15:0] w, int c);
        if (c < 32) return 2'b11;
        if (c == 32) return 2'b10;
        if (c == 33) return 2'b11;
        if (c == 34) return rd ? 2'b11 : 2'b10;
        if (c == 35) return rd ? 2'b10 : 2'b11;
        if (c < 41) return {1'b1, a[40 - c]};
        if (c < 46) return {1'b1, r[45 - c]};
        if (rd) return 2'b00;
        if (c < 48) return 2'b00;
        if (c < 64) return {1'b1, w[63 - c]};
        return 2'b00;
    endfunction

    function automatic string cell_tag(bit rd, int c);
        if (c < 32) return "R1";
        if (c < 36) return "R2";
        if (c < 46) return "R3";
        return rd ? "R5" : "R4";
    endfunction

    task automatic frame(input bit rd, input logic [4:0] a, input logic [4:0] r,
                         input logic [15:0] w, input logic [15:0] v, input bit poke);
        int ncell;
        int cyc;
        int busy_bad;
        logic [15:0] exp_rd;
        ncell    = rd ? 64 : 65;
        busy_bad = 0;
        @(negedge clk);
        phy_val  = v;
        cell_cnt = 0;
        rd_nwr   = rd;
        pa       = a;
        ra       = r;
        wd       = w;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc   = 1;
        while (!done && cyc < 5000) begin
            if (!busy) busy_bad++;
            if (poke && cyc == 40) begin
                start  = 1'b1;
                rd_nwr = ~rd;
                pa     = ~a;
                ra     = ~r;
                wd     = ~w;
            end else if (poke && cyc == 41) begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(busy_bad == 0, "R8", "busy low mid-frame count", busy_bad, 0);
        chk(!busy, "R8", "busy with done", busy, 0);
        chk(cyc == ncell * 2 * H + 1, "R6", "cycles to done", cyc, ncell * 2 * H + 1);
        chk(cell_cnt == ncell, rd ? "R5" : "R4", "cell count", cell_cnt, ncell);
        for (int c = 0; c < ncell; c++) begin
            logic [1:0] e;
            e = exp_cell(rd, a, r, w, c);
            chk({log_oe[c], log_mdo[c]} === e, cell_tag(rd, c), $sformatf("cell %0d oe,mdo", c),
                {30'd0, log_oe[c], log_mdo[c]}, {30'd0, e});
        end
        exp_rd = rd ? v : last_rd;
        chk(rd_data == exp_rd, rd ? "R5" : "R9", "rd_data", rd_data, exp_rd);
        last_rd = exp_rd;
        @(negedge clk);
        chk(!done, "R8", "done width", done, 0);
        chk({mdc, mdo, mdo_en} == 3'b000, "R7", "idle pins", {mdc, mdo, mdo_en}, 0);
    endtask

    initial begin
        #(5ns * 150000);
        if (!fin) begin
            n_chk++;
            n_bad++;
            $display("FAIL R6 watchdog expired: got 1 expected 0");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd31337));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy, "R7", "reset busy", busy, 0);
        chk(!done, "R7", "reset done", done, 0);
        chk({mdc, mdo, mdo_en} == 3'b000, "R7", "reset pins", {mdc, mdo, mdo_en}, 0);
        chk(rd_data == 16'h0, "R7", "reset rd_data", rd_data, 0);

        // directed corners
        frame(1'b1, 5'h1F, 5'h00, 16'h0000, 16'hFFFF, 1'b0);
        frame(1'b0, 5'h00, 5'h1F, 16'hAAAA, 16'h1234, 1'b0);
        frame(1'b1, 5'h15, 5'h0A, 16'h0000, 16'h0000, 1'b1);
        frame(1'b1, 5'h01, 5'h10, 16'h0000, 16'h8001, 1'b0);
        frame(1'b0, 5'h10, 5'h01, 16'h8001, 16'h0000, 1'b1);

        // random frames
        for (int i = 0; i < 16; i++) begin
            frame(bit'($urandom % 2), 5'($urandom), 5'($urandom),
                  16'($urandom), 16'($urandom), bit'(i % 2));
        end

        fin = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule